// File: doc/BRIEF.md
# Memory Module Descriptor Integrity Verifier

This block checks the integrity of a module descriptor image while its bytes stream past in ascending index order. Each byte arrives with its index; a start pulse opens a new run and selects one of two check schemes. The older scheme keeps an 8-bit running total of the leading bytes and compares it with a stored check byte. The newer scheme runs a 16-bit CRC over a leading range whose length the image's first byte selects, and compares it with a stored 16-bit value.

When the last check byte of the selected scheme is accepted, the block raises a sticky done flag on the next cycle. At the same time it reports whether the image matched and presents the value it computed. The block sits behind whatever logic fetches the bytes, and it decodes no descriptor fields.

Top module: `spd_integrity_check`

## Requirements
- R1: After reset, done, pass and calc_val are 0, and bytes offered before the first start pulse are ignored: no done rises.
- R2: A start pulse clears done, pass, calc_val and both accumulators, and latches fmt (0 = 8-bit sum scheme, 1 = CRC scheme). A byte offered in the same cycle as start counts as the first byte of the new run.
- R3: In the sum scheme, bytes with index 0 to 62 are added modulo 256. At done, calc_val holds that total in bits 7:0, with bits 15:8 at 0.
- R4: In the sum scheme, one cycle after the byte with index 63 is accepted, done is 1 and pass is 1 exactly when that byte equals the total itself (no negation or complement).
- R5: In the CRC scheme, the CRC uses polynomial 0x1021 with initial value 0 and no reflection, and takes each byte MSB first. At done, calc_val holds the CRC.
- R6: In the CRC scheme, bit 7 of the byte with index 0 selects the coverage. When it is 1, bytes 0 to 116 are covered; when it is 0, bytes 0 to 125 are covered. Uncovered bytes do not change the CRC.
- R7: In the CRC scheme, the stored CRC is the byte at index 126 (low half) and the byte at index 127 (high half). One cycle after index 127 is accepted, done is 1 and pass is 1 exactly when the stored value equals the CRC.
- R8: Once done is 1 it stays 1, and pass and calc_val stay unchanged, until the next start. Bytes offered meanwhile are ignored.
- R9: A cycle with byte_vld at 0 has no effect, so the bytes may arrive with idle cycles between them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Opens a new run and latches fmt |
| fmt | input | 1 | Scheme select: 0 sum, 1 CRC |
| byte_vld | input | 1 | Byte on byte_dat/byte_idx is offered |
| byte_idx | input | 7 | Index of the offered byte |
| byte_dat | input | 8 | Offered byte value |
| done | output | 1 | Verdict available (sticky until start) |
| pass | output | 1 | Stored check value matched |
| calc_val | output | 16 | Computed sum or CRC |

## Verification
The two functions that can fall in the same cycle are opening a run and accepting a byte. The design must clear its accumulators and fold in the incoming byte at once, and in the CRC scheme it must also take the coverage select from that very byte. The bench provokes this by raising start together with byte 0 in several runs of both schemes, with bit 7 of byte 0 set and clear. It judges the outcome by the final calc_val and pass, which would differ from the bench model if byte 0 were lost or the coverage select were stale.

// File: rtl/spd_chk_pkg.sv
package spd_chk_pkg;
  typedef enum logic {
    SCHEME_SUM = 1'b0,
    SCHEME_CRC = 1'b1
  } scheme_e;
endpackage

// File: rtl/spd_sum_acc.sv
module spd_sum_acc #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          en,
  input  logic [DW-1:0] din,
  output logic [DW-1:0] sum_q
);
  always_ff @(posedge clk) begin
    if (rst)      sum_q <= '0;
    else if (clr) sum_q <= en ? din : '0;
    else if (en)  sum_q <= sum_q + din;
  end

  // R9: no enable and no clear leaves the total alone
  p_sum_idle_r9: assert property (@(posedge clk) disable iff (rst)
    (!clr && !en) |=> $stable(sum_q));
endmodule

// File: rtl/spd_crc_acc.sv
module spd_crc_acc #(
  parameter int          DW   = 8,
  parameter int          CW   = 16,
  parameter logic [CW-1:0] POLY = 16'h1021
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          en,
  input  logic [DW-1:0] din,
  output logic [CW-1:0] crc_q
);
  function automatic logic [CW-1:0] step(input logic [CW-1:0] c, input logic [DW-1:0] d);
    logic [CW-1:0] r;
    r = c;
    for (int b = DW - 1; b >= 0; b--) begin
      if (r[CW-1] ^ d[b]) r = (r << 1) ^ POLY;
      else                r = r << 1;
    end
    return r;
  endfunction

  logic [CW-1:0] base;
  assign base = clr ? '0 : crc_q;

  always_ff @(posedge clk) begin
    if (rst)          crc_q <= '0;
    else if (en)      crc_q <= step(base, din);
    else if (clr)     crc_q <= '0;
  end

  // R6: bytes outside the coverage leave the CRC unchanged
  p_crc_idle_r6: assert property (@(posedge clk) disable iff (rst)
    (!clr && !en) |=> $stable(crc_q));
endmodule

// File: rtl/spd_verdict.sv
module spd_verdict #(
  parameter int DW = 8,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic          sum_fin,
  input  logic          crc_fin,
  input  logic [DW-1:0] sum_q,
  input  logic [CW-1:0] crc_q,
  input  logic [DW-1:0] lo_q,
  input  logic [DW-1:0] din,
  output logic          done,
  output logic          pass,
  output logic [CW-1:0] calc_val
);
  always_ff @(posedge clk) begin
    if (rst || start) begin
      done     <= 1'b0;
      pass     <= 1'b0;
      calc_val <= '0;
    end else if (sum_fin) begin
      done     <= 1'b1;
      pass     <= (din == sum_q);
      calc_val <= CW'(sum_q);
    end else if (crc_fin) begin
      done     <= 1'b1;
      pass     <= ({din, lo_q} == crc_q);
      calc_val <= crc_q;
    end
  end

  // R8: verdict holds until a new run opens
  p_done_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (done && !start) |=> (done && $stable(pass) && $stable(calc_val)));
  // R2: a start pulse withdraws the verdict
  p_start_clear_r2: assert property (@(posedge clk) disable iff (rst)
    start |=> !done);
  // R4: done only rises after a final check byte
  p_done_rise_r4: assert property (@(posedge clk) disable iff (rst)
    $rose(done) |-> $past(sum_fin || crc_fin));
endmodule

// File: rtl/spd_integrity_check.sv
module spd_integrity_check #(
  parameter int DW          = 8,
  parameter int IDX_W       = 7,
  parameter int CW          = 16,
  parameter int SUM_LAST    = 62,
  parameter int CRC_LONG    = 125,
  parameter int CRC_SHORT   = 116,
  parameter int CRC_LO_IDX  = 126,
  parameter logic [CW-1:0] POLY = 16'h1021
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             fmt,
  input  logic             byte_vld,
  input  logic [IDX_W-1:0] byte_idx,
  input  logic [DW-1:0]    byte_dat,
  output logic             done,
  output logic             pass,
  output logic [CW-1:0]    calc_val
);
  import spd_chk_pkg::*;

  localparam logic [IDX_W-1:0] I_SUM_LAST = IDX_W'(SUM_LAST);
  localparam logic [IDX_W-1:0] I_SUM_CHK  = IDX_W'(SUM_LAST + 1);
  localparam logic [IDX_W-1:0] I_LONG     = IDX_W'(CRC_LONG);
  localparam logic [IDX_W-1:0] I_SHORT    = IDX_W'(CRC_SHORT);
  localparam logic [IDX_W-1:0] I_LO       = IDX_W'(CRC_LO_IDX);
  localparam logic [IDX_W-1:0] I_HI       = IDX_W'(CRC_LO_IDX + 1);

  scheme_e          mode_q, mode_e;
  logic             armed_q, short_q, short_e, live, acc;
  logic             sum_en, crc_en, sum_fin, crc_fin;
  logic [IDX_W-1:0] lim;
  logic [DW-1:0]    lo_q, sum_q;
  logic [CW-1:0]    crc_q;

  assign mode_e  = start ? scheme_e'(fmt) : mode_q;
  assign live    = start | (armed_q & ~done);
  assign acc     = byte_vld & live;
  assign short_e = (byte_idx == '0) ? byte_dat[DW-1] : (start ? 1'b0 : short_q);
  assign lim     = short_e ? I_SHORT : I_LONG;
  assign sum_en  = acc & (mode_e == SCHEME_SUM) & (byte_idx <= I_SUM_LAST);
  assign crc_en  = acc & (mode_e == SCHEME_CRC) & (byte_idx <= lim);
  assign sum_fin = acc & (mode_e == SCHEME_SUM) & (byte_idx == I_SUM_CHK);
  assign crc_fin = acc & (mode_e == SCHEME_CRC) & (byte_idx == I_HI);

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q  <= SCHEME_SUM;
      armed_q <= 1'b0;
      short_q <= 1'b0;
      lo_q    <= '0;
    end else begin
      if (start) begin
        mode_q  <= scheme_e'(fmt);
        armed_q <= 1'b1;
      end
      if (start || (acc && byte_idx == '0)) short_q <= short_e;
      if (start)                             lo_q <= '0;
      if (acc && byte_idx == I_LO)           lo_q <= byte_dat;
    end
  end

  spd_sum_acc #(.DW(DW)) i_sum (
    .clk(clk), .rst(rst), .clr(start), .en(sum_en), .din(byte_dat), .sum_q(sum_q));

  spd_crc_acc #(.DW(DW), .CW(CW), .POLY(POLY)) i_crc (
    .clk(clk), .rst(rst), .clr(start), .en(crc_en), .din(byte_dat), .crc_q(crc_q));

  spd_verdict #(.DW(DW), .CW(CW)) i_verdict (
    .clk(clk), .rst(rst), .start(start), .sum_fin(sum_fin), .crc_fin(crc_fin),
    .sum_q(sum_q), .crc_q(crc_q), .lo_q(lo_q), .din(byte_dat),
    .done(done), .pass(pass), .calc_val(calc_val));

  // R1: nothing is accepted before the first start
  p_idle_until_start_r1: assert property (@(posedge clk) disable iff (rst)
    (!armed_q && !start) |=> !done);
  // R4: a pass verdict never appears without done
  p_pass_needs_done_r4: assert property (@(posedge clk) disable iff (rst)
    pass |-> done);
  // R3: the sum scheme never reports upper bits
  p_sum_upper_zero_r3: assert property (@(posedge clk) disable iff (rst)
    (done && mode_q == SCHEME_SUM) |-> (calc_val[CW-1:DW] == '0));
endmodule

// File: tb/test_spd_integrity_check.sv
module test_spd_integrity_check;
  logic        clk = 0, rst = 1, start = 0, fmt = 0, byte_vld = 0;
  logic [6:0]  byte_idx = 0;
  logic [7:0]  byte_dat = 0;
  logic        done, pass;
  logic [15:0] calc_val;
  int          n_run = 0, n_fail = 0;
  logic [7:0]  img [0:127];

  always #2.5 clk = ~clk;

  spd_integrity_check i_spd_integrity_check (.*);

  initial begin
    #1000000;
    n_fail++;
    $display("FAIL watchdog: run hung");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  function automatic logic [7:0] ref_sum();
    logic [7:0] s = 0;
    for (int i = 0; i <= 62; i++) s += img[i];
    return s;
  endfunction

  function automatic logic [15:0] ref_crc();
    logic [15:0] c = 0;
    int last = img[0][7] ? 116 : 125;
    for (int i = 0; i <= last; i++)
      for (int b = 7; b >= 0; b--) begin
        logic fb = c[15] ^ img[i][b];
        c = {c[14:0], 1'b0};
        if (fb) c ^= 16'h1021;
      end
    return c;
  endfunction

  task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic send(int idx, bit with_start, bit f);
    @(negedge clk);
    start = with_start; fmt = f;
    byte_vld = 1; byte_idx = 7'(idx); byte_dat = img[idx];
    @(posedge clk);
    @(negedge clk);
    start = 0; byte_vld = 0;
  endtask

  task automatic pulse_start(bit f);
    @(negedge clk); start = 1; fmt = f;
    @(negedge clk); start = 0;
  endtask

  // stream a whole run; gaps adds idle cycles at random
  task automatic run(bit f, bit joint, int gaps);
    int last = f ? 127 : 63;
    if (!joint) pulse_start(f);
    for (int i = 0; i <= last; i++) begin
      if (gaps != 0 && ($urandom % 4) == 0)
        repeat ($urandom % gaps) @(negedge clk);
      if (i == last) begin
        n_run++;
        if (done !== 1'b0) begin n_fail++; $display("FAIL R4: done early"); end
      end
      send(i, joint && i == 0, f);
    end
  endtask

  task automatic fill_rand();
    for (int i = 0; i < 128; i++) img[i] = 8'($urandom);
  endtask

  task automatic seal_crc();
    logic [15:0] c = ref_crc();
    img[126] = c[7:0]; img[127] = c[15:8];
  endtask

  initial begin
    logic [15:0] c;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk("R1 done", {15'd0, done}, 16'd0);
    chk("R1 pass", {15'd0, pass}, 16'd0);
    chk("R1 calc_val", calc_val, 16'd0);
    // bytes before any start are ignored
    fill_rand(); img[63] = ref_sum();
    for (int i = 0; i <= 63; i++) send(i, 0, 0);
    chk("R1 ignored pre-start", {15'd0, done}, 16'd0);

    // sum scheme, matching stored byte (not negated)
    fill_rand(); img[63] = ref_sum();
    run(0, 0, 0);
    chk("R4 done", {15'd0, done}, 16'd1);
    chk("R4 pass", {15'd0, pass}, 16'd1);
    chk("R3 calc_val", calc_val, {8'd0, ref_sum()});
    // R8: later bytes ignored
    for (int i = 0; i <= 63; i++) begin img[i] = 8'hA5; send(i, 0, 0); end
    chk("R8 done held", {15'd0, done}, 16'd1);
    chk("R8 pass held", {15'd0, pass}, 16'd1);
    // R2: start clears
    pulse_start(1);
    chk("R2 done clr", {15'd0, done}, 16'd0);
    chk("R2 calc clr", calc_val, 16'd0);

    // complemented check byte must fail
    fill_rand(); img[63] = ~ref_sum();
    run(0, 0, 0);
    chk("R4 negated fails", {15'd0, pass}, 16'd0);
    chk("R3 calc_val", calc_val, {8'd0, ref_sum()});

    // CRC long coverage
    fill_rand(); img[0][7] = 0; seal_crc();
    run(1, 0, 3);
    chk("R7 done", {15'd0, done}, 16'd1);
    chk("R7 pass long", {15'd0, pass}, 16'd1);
    chk("R5 crc long", calc_val, ref_crc());

    // CRC short coverage; byte 120 outside the range
    fill_rand(); img[0][7] = 1; seal_crc(); img[120] = ~img[120];
    run(1, 0, 0);
    chk("R6 short ignores 120", {15'd0, pass}, 16'd1);
    chk("R6 crc short", calc_val, ref_crc());

    // long coverage: a change at 120 must be seen
    fill_rand(); img[0][7] = 0; seal_crc(); c = ref_crc(); img[120] = ~img[120];
    run(1, 0, 0);
    chk("R6 long sees 120", {15'd0, pass}, 16'd0);
    chk("R6 crc changed", calc_val, ref_crc());

    // swapped stored halves must fail
    fill_rand(); img[0][7] = 1; seal_crc(); c = ref_crc();
    if (c[7:0] != c[15:8]) begin
      img[126] = c[15:8]; img[127] = c[7:0];
      run(1, 0, 0);
      chk("R7 byte order", {15'd0, pass}, 16'd0);
    end

    // start together with byte 0, both schemes, random
    for (int k = 0; k < 12; k++) begin
      bit f = k[0];
      fill_rand();
      if (f) begin seal_crc(); if ($urandom % 3 == 0) img[127] ^= 8'h01; end
      else img[63] = ($urandom % 3 == 0) ? ref_sum() + 8'd1 : ref_sum();
      run(f, 1, 4);
      if (f) begin
        chk("R2 joint crc", calc_val, ref_crc());
        chk("R9 joint crc pass", {15'd0, pass}, {15'd0, {img[127], img[126]} == ref_crc()});
      end else begin
        chk("R2 joint sum", calc_val, {8'd0, ref_sum()});
        chk("R9 joint sum pass", {15'd0, pass}, {15'd0, img[63] == ref_sum()});
      end
    end

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule